// File: doc/BRIEF.md
# Level-Banked Accumulator File

This block holds the working accumulators of a small processor that runs four priority levels. Each level owns one 16-bit accumulator and a carry/overflow flag pair. The active-level input steers every arithmetic or logical operation to the accumulator of that level. Switching level therefore swaps the working register at once, with no save or restore sequence.

An operation combines the selected accumulator, as the implied operand, with an explicit operand. The explicit operand comes from either the storage data bus or the index-register bus. The result goes back into the same accumulator and is also reported on a registered result port. A separate console port reads or overwrites any accumulator by explicit number, independently of the active level.

Top module: `level_acc_file`

## Requirements
- R1: After a synchronous reset all four accumulators and all flags are zero, `res_valid` is low, and `cur_acc` and `con_rdata` read zero.
- R2: An operation presented with `op_valid` high acts only on the accumulator numbered by `act_level` in that cycle. The other three accumulators keep their values.
- R3: `op_src` = 0 takes the explicit operand from `stor_data`, and `op_src` = 1 takes it from `idx_data`.
- R4: `op_code` selects the function: 0 load operand, 1 add, 2 subtract (accumulator minus operand), 3 AND, 4 OR, 5 XOR. The result is written to the selected accumulator. One cycle later it appears on `res_data` with `res_valid` high.
- R5: Add sets carry to the unsigned carry out of bit 15, and sets overflow when the result sign differs from the sign that both operands share.
- R6: Subtract sets carry to 1 when a borrow occurs (accumulator below operand, unsigned). It sets overflow when the operand signs differ and the result sign differs from the accumulator sign.
- R7: Flags are stored per level. Load, AND, OR and XOR leave that level's flags unchanged. `res_carry` and `res_ovf` report that level's flags as they stand after the operation.
- R8: `op_code` values 6 and 7 are ignored: no accumulator or flag changes, and `res_valid` stays low.
- R9: `con_rdata` shows, one cycle after a clock edge, the accumulator numbered by `con_sel` as it stood before that edge.
- R10: With `con_we` high, `con_wdata` is written to the accumulator numbered by `con_sel`, and that level's flags are untouched.
- R11: When a console write and an operation target the same accumulator in one cycle, the console value is stored. The operation's value and flag updates are dropped, but its result is still reported on `res_data`.
- R12: `cur_acc`, `cur_carry` and `cur_ovf` give a registered view of the accumulator and flags of the level on `act_level` one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Function select |
| op_src | input | 1 | Explicit operand source: 0 storage, 1 index |
| stor_data | input | 16 | Storage data operand |
| idx_data | input | 16 | Index register operand |
| act_level | input | 2 | Active priority level |
| con_we | input | 1 | Console write strobe |
| con_sel | input | 2 | Console accumulator number |
| con_wdata | input | 16 | Console write value |
| con_rdata | output | 16 | Console read value (registered) |
| cur_acc | output | 16 | Active level accumulator (registered) |
| cur_carry | output | 1 | Active level carry flag (registered) |
| cur_ovf | output | 1 | Active level overflow flag (registered) |
| res_valid | output | 1 | Result strobe |
| res_data | output | 16 | Operation result |
| res_carry | output | 1 | Level carry after the operation |
| res_ovf | output | 1 | Level overflow after the operation |

## Verification
The bench builds the block with its default parameters: a 16-bit data width and four levels. At this width the sign boundaries 0x7FFF/0x8000 and the wrap at 0xFFFF can be reached with single operands. Every level can be addressed with a two-bit selector. A vector table runs operations that hop between levels in consecutive cycles, so results are checked against each level's own history. Directed cases then cover same-target and different-target console/operation collisions, ignored codes, and the registered active-level view.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5
  } op_e;

  localparam logic [2:0] OP_LAST = 3'd5;

  function automatic logic op_legal(input logic [2:0] code);
    return code <= OP_LAST;
  endfunction
endpackage

// File: rtl/acc_opsel.sv
module acc_opsel #(
  parameter int W = 16
) (
  input  logic         src,
  input  logic [W-1:0] stor,
  input  logic [W-1:0] idx,
  output logic [W-1:0] opnd
);
  always_comb opnd = src ? idx : stor;
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 16
) (
  input  logic [2:0]   code,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  input  logic         v_in,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out
);
  import acc_pkg::*;
  localparam int MSB = W - 1;

  logic [W:0] sum, dif;

  always_comb begin
    sum   = {1'b0, a} + {1'b0, b};
    dif   = {1'b0, a} - {1'b0, b};
    res   = b;
    c_out = c_in;
    v_out = v_in;
    case (op_e'(code))
      OP_LOAD: res = b;
      OP_ADD: begin
        res   = sum[W-1:0];
        c_out = sum[W];
        v_out = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      end
      OP_SUB: begin
        res   = dif[W-1:0];
        c_out = dif[W];
        v_out = (a[MSB] != b[MSB]) && (dif[MSB] != a[MSB]);
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = b;
    endcase
  end
endmodule

// File: rtl/acc_bank.sv
module acc_bank #(
  parameter int W = 16,
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alu_we,
  input  logic [SW-1:0] alu_sel,
  input  logic [W-1:0]  alu_data,
  input  logic          alu_c,
  input  logic          alu_v,
  input  logic          con_we,
  input  logic [SW-1:0] con_sel,
  input  logic [W-1:0]  con_data,
  input  logic [SW-1:0] rda_sel,
  output logic [W-1:0]  rda_data,
  output logic          rda_c,
  output logic          rda_v,
  input  logic [SW-1:0] rdb_sel,
  output logic [W-1:0]  rdb_data
);
  logic [W-1:0] acc [N];
  logic         fc  [N];
  logic         fv  [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic con_hit, alu_hit;
    assign con_hit = con_we && (con_sel == SW'(i));
    assign alu_hit = alu_we && (alu_sel == SW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        acc[i] <= '0;
        fc[i]  <= 1'b0;
        fv[i]  <= 1'b0;
      end else if (con_hit) begin
        acc[i] <= con_data;
      end else if (alu_hit) begin
        acc[i] <= alu_data;
        fc[i]  <= alu_c;
        fv[i]  <= alu_v;
      end
    end
  end

  always_comb begin
    rda_data = acc[rda_sel];
    rda_c    = fc[rda_sel];
    rda_v    = fv[rda_sel];
    rdb_data = acc[rdb_sel];
  end
endmodule

// File: rtl/level_acc_file.sv
module level_acc_file #(
  parameter int DATA_W = 16,
  parameter int NUM_LVL = 4,
  localparam int LVL_W = $clog2(NUM_LVL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic              op_src,
  input  logic [DATA_W-1:0] stor_data,
  input  logic [DATA_W-1:0] idx_data,
  input  logic [LVL_W-1:0]  act_level,
  input  logic              con_we,
  input  logic [LVL_W-1:0]  con_sel,
  input  logic [DATA_W-1:0] con_wdata,
  output logic [DATA_W-1:0] con_rdata,
  output logic [DATA_W-1:0] cur_acc,
  output logic              cur_carry,
  output logic              cur_ovf,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              res_carry,
  output logic              res_ovf
);
  import acc_pkg::*;

  logic              go;
  logic [DATA_W-1:0] opnd, acc_a, acc_b, alu_res;
  logic              a_c, a_v, n_c, n_v;

  assign go = op_valid && op_legal(op_code);

  acc_opsel #(.W(DATA_W)) u_opsel (
    .src(op_src), .stor(stor_data), .idx(idx_data), .opnd(opnd)
  );

  acc_alu #(.W(DATA_W)) u_alu (
    .code(op_code), .a(acc_a), .b(opnd), .c_in(a_c), .v_in(a_v),
    .res(alu_res), .c_out(n_c), .v_out(n_v)
  );

  acc_bank #(.W(DATA_W), .N(NUM_LVL)) u_bank (
    .clk(clk), .rst(rst),
    .alu_we(go), .alu_sel(act_level), .alu_data(alu_res),
    .alu_c(n_c), .alu_v(n_v),
    .con_we(con_we), .con_sel(con_sel), .con_data(con_wdata),
    .rda_sel(act_level), .rda_data(acc_a), .rda_c(a_c), .rda_v(a_v),
    .rdb_sel(con_sel), .rdb_data(acc_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      con_rdata <= '0;
      cur_acc   <= '0;
      cur_carry <= 1'b0;
      cur_ovf   <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_carry <= 1'b0;
      res_ovf   <= 1'b0;
    end else begin
      con_rdata <= acc_b;
      cur_acc   <= acc_a;
      cur_carry <= a_c;
      cur_ovf   <= a_v;
      res_valid <= go;
      if (go) begin
        res_data  <= alu_res;
        res_carry <= n_c;
        res_ovf   <= n_v;
      end
    end
  end
endmodule

// File: rtl/acc_file_chk.sv
module acc_file_chk #(
  parameter int DATA_W = 16,
  parameter int LVL_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic              op_src,
  input logic [DATA_W-1:0] stor_data,
  input logic [DATA_W-1:0] idx_data,
  input logic [LVL_W-1:0]  act_level,
  input logic              con_we,
  input logic [LVL_W-1:0]  con_sel,
  input logic [DATA_W-1:0] con_wdata,
  input logic [DATA_W-1:0] con_rdata,
  input logic [DATA_W-1:0] cur_acc,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data
);
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!res_valid && cur_acc == '0 && con_rdata == '0));

  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > 3'd5) |=> !res_valid);

  a_r4_legal_reports: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code <= 3'd5) |=> res_valid);

  a_r3_load_source: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd0) |=>
      res_data == $past(op_src ? idx_data : stor_data));

  a_r10_console_store: assert property (@(posedge clk) disable iff (rst)
    con_we |=> ((con_sel == $past(con_sel) && !con_we &&
                 !(op_valid && op_code <= 3'd5 && act_level == con_sel))
                |=> con_rdata == $past(con_wdata, 2)));
endmodule

bind level_acc_file acc_file_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .op_src(op_src), .stor_data(stor_data), .idx_data(idx_data),
  .act_level(act_level), .con_we(con_we), .con_sel(con_sel),
  .con_wdata(con_wdata), .con_rdata(con_rdata), .cur_acc(cur_acc),
  .res_valid(res_valid), .res_data(res_data)
);

// File: tb/level_acc_file_tb.sv
`timescale 1ns/1ps
module level_acc_file_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic        op_src = 1'b0;
  logic [15:0] stor_data = '0, idx_data = '0;
  logic [1:0]  act_level = '0;
  logic        con_we = 1'b0;
  logic [1:0]  con_sel = '0;
  logic [15:0] con_wdata = '0;
  logic [15:0] con_rdata, cur_acc, res_data;
  logic        cur_carry, cur_ovf, res_valid, res_carry, res_ovf;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  level_acc_file u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_src(op_src), .stor_data(stor_data), .idx_data(idx_data),
    .act_level(act_level), .con_we(con_we), .con_sel(con_sel),
    .con_wdata(con_wdata), .con_rdata(con_rdata), .cur_acc(cur_acc),
    .cur_carry(cur_carry), .cur_ovf(cur_ovf), .res_valid(res_valid),
    .res_data(res_data), .res_carry(res_carry), .res_ovf(res_ovf)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        src;
    logic [1:0]  lvl;
    logic [15:0] opnd;
    logic [15:0] res;
    logic        c;
    logic        v;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 2'd0, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0},
    '{3'd1, 1'b1, 2'd0, 16'h0001, 16'h8000, 1'b0, 1'b1},
    '{3'd0, 1'b0, 2'd1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0},
    '{3'd1, 1'b0, 2'd1, 16'h0001, 16'h0000, 1'b1, 1'b0},
    '{3'd2, 1'b1, 2'd2, 16'h0001, 16'hFFFF, 1'b1, 1'b0},
    '{3'd3, 1'b0, 2'd0, 16'h0F0F, 16'h0000, 1'b0, 1'b1},
    '{3'd4, 1'b1, 2'd3, 16'h1234, 16'h1234, 1'b0, 1'b0},
    '{3'd5, 1'b0, 2'd3, 16'hFFFF, 16'hEDCB, 1'b0, 1'b0},
    '{3'd2, 1'b0, 2'd0, 16'h0001, 16'hFFFF, 1'b1, 1'b0},
    '{3'd2, 1'b0, 2'd1, 16'h8000, 16'h8000, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_op(input logic [2:0] op, input logic src, input logic [1:0] lvl,
                          input logic [15:0] opnd);
    op_valid  = 1'b1;
    op_code   = op;
    op_src    = src;
    act_level = lvl;
    stor_data = src ? ~opnd : opnd;
    idx_data  = src ? opnd : ~opnd;
  endtask

  task automatic con_read(input logic [1:0] sel, output logic [15:0] val);
    op_valid = 1'b0;
    con_we   = 1'b0;
    con_sel  = sel;
    @(negedge clk);
    val = con_rdata;
  endtask

  logic [15:0] rd;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 res_valid", {31'd0, res_valid}, 32'd0);
    check("R1 cur_acc", {16'd0, cur_acc}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      con_read(2'(i), rd);
      check("R1 acc zero", {16'd0, rd}, 32'd0);
    end

    // R2 R3 R4 R5 R6 R7: vector table, one operation per cycle
    for (int i = 0; i < NV; i++) begin
      drive_op(VECS[i].op, VECS[i].src, VECS[i].lvl, VECS[i].opnd);
      @(negedge clk);
      check("R4 R5 R6 R7 vector",
            {13'd0, res_valid, res_data, res_carry, res_ovf},
            {13'd0, 1'b1, VECS[i].res, VECS[i].c, VECS[i].v});
    end

    // R2 R9: each level holds its own history
    con_read(2'd0, rd); check("R2 R9 acc0", {16'd0, rd}, 32'h0000FFFF);
    con_read(2'd1, rd); check("R2 R9 acc1", {16'd0, rd}, 32'h00008000);
    con_read(2'd2, rd); check("R2 R9 acc2", {16'd0, rd}, 32'h0000FFFF);
    con_read(2'd3, rd); check("R2 R9 acc3", {16'd0, rd}, 32'h0000EDCB);

    // R12: registered view of the active level
    act_level = 2'd1;
    @(negedge clk);
    check("R12 cur view", {14'd0, cur_acc, cur_carry, cur_ovf}, {14'd0, 16'h8000, 1'b1, 1'b1});

    // R11: same-target collision, console wins, flags kept
    drive_op(3'd2, 1'b0, 2'd2, 16'h0001);
    con_we = 1'b1; con_sel = 2'd2; con_wdata = 16'h2222;
    @(negedge clk);
    check("R11 result reported", {13'd0, res_valid, res_data, res_carry, res_ovf},
          {13'd0, 1'b1, 16'hFFFE, 1'b0, 1'b0});
    con_read(2'd2, rd); check("R11 console kept", {16'd0, rd}, 32'h00002222);
    act_level = 2'd2;
    @(negedge clk);
    check("R11 flags kept", {30'd0, cur_carry, cur_ovf}, {30'd0, 1'b1, 1'b0});

    // R10: console write to one level, operation on another in the same cycle
    drive_op(3'd0, 1'b1, 2'd3, 16'h5555);
    con_we = 1'b1; con_sel = 2'd0; con_wdata = 16'hABCD;
    @(negedge clk);
    con_read(2'd0, rd); check("R10 console write", {16'd0, rd}, 32'h0000ABCD);
    con_read(2'd3, rd); check("R2 other level op", {16'd0, rd}, 32'h00005555);
    act_level = 2'd0;
    @(negedge clk);
    check("R10 flags untouched", {30'd0, cur_carry, cur_ovf}, {30'd0, 1'b1, 1'b0});

    // R8: illegal code ignored
    drive_op(3'd7, 1'b0, 2'd3, 16'h0000);
    @(negedge clk);
    check("R8 no result", {31'd0, res_valid}, 32'd0);
    con_read(2'd3, rd); check("R8 acc3 unchanged", {16'd0, rd}, 32'h00005555);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule